// File: doc/BRIEF.md
# Preemptive Priority Command Arbiter

This block collects conversion commands from a small set of prioritized command queues and writes them, at most one per clock, into a two-entry command buffer that a converter drains. Queue 0 is the urgent queue. Among all queues the lowest index wins. Normally an urgent command simply takes the next free buffer slot, so it can wait behind up to two commands that entered earlier from lower-priority queues.

With preemption enabled, an urgent request that finds a lower-priority command in the buffer starts a recovery sequence. The buffer contents are pulled into a side store and the buffer output is withdrawn. The converter is asked to abort, and the block waits for its done handshake. The urgent queue is then drained into the buffer until it has nothing left. The saved commands are written back in their original order, and only then does normal arbitration resume.

Every queue input and the buffer output use valid/ready. A queue's command is taken on a clock edge where its valid and ready are both high. Ready is only offered to the granted queue, and only while the buffer has a free slot. A queue must hold its valid and command until they are taken. The buffer output presents its oldest entry and holds it while ready is low. The one exception is the cycle after a preemption, when the output valid drops so the entries can be saved. The abort request and abort-done pins are plain levels.

Top module: `prio_abort_ctrl`

## Requirements
- R1: When the block is arbitrating normally and the buffer has a free slot, q_ready is one-hot on the lowest-index queue whose q_valid is high, or all zero if no queue is valid. At most one command is accepted per clock.
- R2: The buffer holds two commands. With two stored, q_ready is all zero. Commands leave on buf_cmd in the order they were accepted. While buf_valid is high and buf_ready is low, buf_cmd stays unchanged, except in a preemption cycle.
- R3: Preemption starts in a cycle where all of the following hold: abort_en is high, q_valid[0] is high, and the buffer holds at least one command from a queue other than 0. In that cycle q_ready is all zero. In the next cycle buf_valid is low. A buffer holding only queue-0 commands does not start preemption.
- R4: abort_req rises two cycles after the preemption cycle and stays high until abort_done is sampled high. While abort_req is high, buf_valid and every q_ready are low.
- R5: In the cycle after abort_done is sampled high with abort_req high, abort_req is low. From then on only queue 0 can see q_ready, for as long as q_valid[0] stays high.
- R6: Once q_valid[0] goes low in the drain phase, the saved commands are written back into the buffer in their original order. They leave before any later command from queues 1 and up, and normal arbitration follows the last of them.
- R7: From the preemption cycle until the last saved command has been written back, q_ready of queues 1 and up stays low.
- R8: With abort_en low, an urgent request never removes buffered commands and never raises abort_req. It takes the next free slot behind the commands already stored.
- R9: If no command remained to save (the buffer emptied in the preemption cycle), normal arbitration resumes in the cycle after q_valid[0] goes low in the drain phase.
- R10: After reset, buf_valid and abort_req are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_en | input | 1 | Allows urgent requests to preempt buffered commands |
| q_valid | input | NQ | Per-queue command valid; bit 0 is the urgent queue |
| q_ready | output | NQ | Per-queue command accept |
| q_cmd | input | NQ*CMD_W | Per-queue command, queue i in bits [i*CMD_W +: CMD_W] |
| buf_valid | output | 1 | Buffer head command is valid |
| buf_ready | input | 1 | Converter takes the head command |
| buf_cmd | output | CMD_W | Buffer head command |
| abort_req | output | 1 | Abort request to the converter |
| abort_done | input | 1 | Converter has aborted and is ready |

## Verification
The main risk is the sequencer getting out of step with the buffer or the side store. A wrong state would show within a cycle or two as a q_ready that is on when it should be off, or off when it should be on. It could also show as an abort request that is missing, sticks high or drops early. A side store that is out of step shows only later, when the restored commands come out missing, duplicated or reordered relative to the urgent commands. The bench therefore logs every command that leaves and compares the whole order after each scenario.

// File: rtl/pqa_pkg.sv
`timescale 1ns/1ps
package pqa_pkg;
  localparam int BUF_DEPTH = 2;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_SAVE,
    ST_ABORT_WAIT,
    ST_URGENT,
    ST_RESTORE
  } pqa_state_e;
endpackage

// File: rtl/pqa_prio_arb.sv
`timescale 1ns/1ps
module pqa_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] below;

  assign below[0] = 1'b0;
  for (genvar g = 1; g < N; g++) begin : g_chain
    assign below[g] = below[g-1] | req[g-1];
  end

  assign gnt = req & ~below;
endmodule

// File: rtl/pqa_cmd_fifo2.sv
`timescale 1ns/1ps
module pqa_cmd_fifo2 #(
  parameter int EW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [EW-1:0] push_ent,
  input  logic          pop,
  output logic [1:0]    cnt,
  output logic [EW-1:0] head,
  output logic [EW-1:0] tail
);
  logic [EW-1:0] slot0, slot1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= 2'd0;
      slot0 <= '0;
      slot1 <= '0;
    end else if (clr) begin
      cnt <= 2'd0;
    end else begin
      unique case ({push, pop})
        2'b01: begin
          slot0 <= slot1;
          cnt   <= cnt - 2'd1;
        end
        2'b10: begin
          if (cnt == 2'd0) slot0 <= push_ent;
          else             slot1 <= push_ent;
          cnt <= cnt + 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) begin
            slot0 <= push_ent;
          end else begin
            slot0 <= slot1;
            slot1 <= push_ent;
          end
        end
        default: ;
      endcase
    end
  end

  assign head = slot0;
  assign tail = slot1;
endmodule

// File: rtl/pqa_side_store.sv
`timescale 1ns/1ps
module pqa_side_store #(
  parameter int EW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    ld_cnt,
  input  logic [EW-1:0] ld_first,
  input  logic [EW-1:0] ld_second,
  input  logic          adv,
  output logic [EW-1:0] cur,
  output logic [1:0]    scnt,
  output logic          last
);
  logic [EW-1:0] ent [pqa_pkg::BUF_DEPTH];
  logic          ridx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt   <= 2'd0;
      ridx   <= 1'b0;
      ent[0] <= '0;
      ent[1] <= '0;
    end else if (load) begin
      ent[0] <= ld_first;
      ent[1] <= ld_second;
      scnt   <= ld_cnt;
      ridx   <= 1'b0;
    end else if (adv) begin
      ridx <= ridx + 1'b1;
    end
  end

  assign cur  = ent[ridx];
  assign last = ({1'b0, ridx} + 2'd1) == scnt;
endmodule

// File: rtl/prio_abort_ctrl.sv
`timescale 1ns/1ps
module prio_abort_ctrl #(
  parameter int NQ    = 4,
  parameter int CMD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                abort_en,
  input  logic [NQ-1:0]       q_valid,
  output logic [NQ-1:0]       q_ready,
  input  logic [NQ*CMD_W-1:0] q_cmd,
  output logic                buf_valid,
  input  logic                buf_ready,
  output logic [CMD_W-1:0]    buf_cmd,
  output logic                abort_req,
  input  logic                abort_done
);
  import pqa_pkg::*;

  localparam int EW = CMD_W + 1;

  pqa_state_e    state, nxt;
  logic [CMD_W-1:0] cmd_arr [NQ];
  logic [NQ-1:0] gnt;
  logic [CMD_W-1:0] sel_cmd;
  logic [1:0]    fcnt, scnt;
  logic [EW-1:0] head, tail, push_ent, cur;
  logic          push, pop, clr, load, adv, last;
  logic          room, low_pending, preempt;

  for (genvar g = 0; g < NQ; g++) begin : g_unpack
    assign cmd_arr[g] = q_cmd[g*CMD_W +: CMD_W];
  end

  pqa_prio_arb #(.N(NQ)) u_arb (
    .req (q_valid),
    .gnt (gnt)
  );

  always_comb begin
    sel_cmd = '0;
    for (int i = 0; i < NQ; i++) begin
      if (gnt[i]) sel_cmd = cmd_arr[i];
    end
  end

  pqa_cmd_fifo2 #(.EW(EW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .push     (push),
    .push_ent (push_ent),
    .pop      (pop),
    .cnt      (fcnt),
    .head     (head),
    .tail     (tail)
  );

  pqa_side_store #(.EW(EW)) u_side (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ld_cnt    (fcnt),
    .ld_first  (head),
    .ld_second (tail),
    .adv       (adv),
    .cur       (cur),
    .scnt      (scnt),
    .last      (last)
  );

  // entry MSB marks a command taken from the urgent queue
  assign room        = fcnt < 2'(BUF_DEPTH);
  assign low_pending = ((fcnt != 2'd0) && !head[EW-1]) ||
                       ((fcnt == 2'd2) && !tail[EW-1]);
  assign preempt     = (state == ST_NORMAL) && abort_en && q_valid[0] && low_pending;

  always_comb begin
    nxt      = state;
    q_ready  = '0;
    push     = 1'b0;
    push_ent = '0;
    clr      = 1'b0;
    load     = 1'b0;
    adv      = 1'b0;
    unique case (state)
      ST_NORMAL: begin
        if (preempt) begin
          nxt = ST_SAVE;
        end else if (room) begin
          q_ready  = gnt;
          push     = |q_valid;
          push_ent = {gnt[0], sel_cmd};
        end
      end
      ST_SAVE: begin
        load = 1'b1;
        clr  = 1'b1;
        nxt  = ST_ABORT_WAIT;
      end
      ST_ABORT_WAIT: begin
        if (abort_done) nxt = ST_URGENT;
      end
      ST_URGENT: begin
        if (q_valid[0]) begin
          if (room) begin
            q_ready[0] = 1'b1;
            push       = 1'b1;
            push_ent   = {1'b1, cmd_arr[0]};
          end
        end else begin
          nxt = (scnt != 2'd0) ? ST_RESTORE : ST_NORMAL;
        end
      end
      ST_RESTORE: begin
        if (room) begin
          push     = 1'b1;
          push_ent = cur;
          adv      = 1'b1;
          if (last) nxt = ST_NORMAL;
        end
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_NORMAL;
    else        state <= nxt;
  end

  assign buf_valid = (fcnt != 2'd0) && (state != ST_SAVE) && (state != ST_ABORT_WAIT);
  assign pop       = buf_valid && buf_ready;
  assign buf_cmd   = head[CMD_W-1:0];
  assign abort_req = (state == ST_ABORT_WAIT);
endmodule

// File: rtl/prio_abort_ctrl_chk.sv
`timescale 1ns/1ps
module prio_abort_ctrl_chk #(
  parameter int NQ    = 4,
  parameter int CMD_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                abort_en,
  input logic [NQ-1:0]       q_valid,
  input logic [NQ-1:0]       q_ready,
  input logic                buf_valid,
  input logic                buf_ready,
  input logic [CMD_W-1:0]    buf_cmd,
  input logic                abort_req,
  input logic                abort_done,
  input logic                preempt,
  input pqa_pkg::pqa_state_e state
);
  import pqa_pkg::*;

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_valid & q_ready)); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready && !preempt |=> buf_valid && $stable(buf_cmd)); // R2

  AST_PREEMPT_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |=> !buf_valid && (q_ready == '0)); // R3

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> !buf_valid && (q_ready == '0)); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req && !abort_done |=> abort_req); // R4

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req && abort_done |=> !abort_req); // R5

  AST_URGENT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_URGENT) |-> (q_ready[NQ-1:1] == '0)); // R5

  AST_LOW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAVE || state == ST_RESTORE) |-> (q_ready == '0)); // R7

  AST_NO_ABORT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL) && !abort_en |=> (state != ST_SAVE)); // R8
endmodule

bind prio_abort_ctrl prio_abort_ctrl_chk #(.NQ(NQ), .CMD_W(CMD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .abort_en   (abort_en),
  .q_valid    (q_valid),
  .q_ready    (q_ready),
  .buf_valid  (buf_valid),
  .buf_ready  (buf_ready),
  .buf_cmd    (buf_cmd),
  .abort_req  (abort_req),
  .abort_done (abort_done),
  .preempt    (preempt),
  .state      (state)
);

// File: tb/test_prio_abort_ctrl.sv
`timescale 1ns/1ps
module test_prio_abort_ctrl;
  localparam int NQ = 4;
  localparam int W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort_en = 1'b0;
  logic [NQ-1:0] q_valid = '0;
  logic [NQ-1:0] q_ready;
  logic [NQ*W-1:0] q_cmd = '0;
  logic buf_valid;
  logic buf_ready = 1'b0;
  logic [W-1:0] buf_cmd;
  logic abort_req;
  logic abort_done = 1'b0;

  int nchk = 0;
  int nfail = 0;
  int nl = 0;
  logic [W-1:0] lg [0:63];

  always #2.5 clk = ~clk;

  prio_abort_ctrl #(.NQ(NQ), .CMD_W(W)) i_prio_abort_ctrl (
    .clk(clk), .rst_n(rst_n), .abort_en(abort_en),
    .q_valid(q_valid), .q_ready(q_ready), .q_cmd(q_cmd),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_cmd(buf_cmd),
    .abort_req(abort_req), .abort_done(abort_done)
  );

  // record every command that leaves the buffer
  always @(negedge clk) begin
    if (rst_n && buf_valid && buf_ready) begin
      if (nl < 64) lg[nl] = buf_cmd;
      nl = nl + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic setc(input int q, input logic [W-1:0] v);
    q_cmd[q*W +: W] = v;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int base;
    // R1 sweep of all request masks while reset keeps the buffer empty
    cyc();
    for (int m = 1; m < 16; m++) begin
      q_valid = 4'(m);
      #1;
      chk("R1 lowest index wins", 32'(q_ready), 32'(4'(m) & (~4'(m) + 4'd1)));
      cyc();
    end
    q_valid = '0;
    cyc();
    rst_n = 1'b1;
    #1;
    chk("R10 buf_valid after reset", 32'(buf_valid), 32'd0);
    chk("R10 abort_req after reset", 32'(abort_req), 32'd0);
    chk("R10 q_ready idle", 32'(q_ready), 32'd0);

    // R2 fill, full, hold, order
    setc(2, 8'h21); setc(3, 8'h31); q_valid = 4'b1100;
    #1 chk("R1 queue 2 over 3", 32'(q_ready), 32'b0100);
    cyc(); setc(2, 8'h22);
    cyc(); q_valid = 4'b1100;
    #1 chk("R2 full blocks", 32'(q_ready), 32'd0);
    chk("R2 head valid", 32'(buf_valid), 32'd1);
    chk("R2 head first", 32'(buf_cmd), 32'h21);
    q_valid = '0;
    cyc();
    chk("R2 stalled head stable", 32'(buf_cmd), 32'h21);
    buf_ready = 1'b1; base = nl;
    cyc(); cyc();
    chk("R2 drained", 32'(buf_valid), 32'd0);
    buf_ready = 1'b0;
    chk("R2 order 1", 32'(lg[base]), 32'h21);
    chk("R2 order 2", 32'(lg[base+1]), 32'h22);

    // R8 urgent without abort enabled
    abort_en = 1'b0;
    setc(1, 8'h11); q_valid = 4'b0010;
    cyc();
    setc(0, 8'h01); q_valid = 4'b0001;
    #1 chk("R8 urgent takes free slot", 32'(q_ready), 32'b0001);
    cyc(); q_valid = '0;
    #1 chk("R8 no abort", 32'(abort_req), 32'd0);
    chk("R8 old head kept", 32'(buf_cmd), 32'h11);
    buf_ready = 1'b1; base = nl;
    cyc(); cyc();
    buf_ready = 1'b0;
    chk("R8 order 1", 32'(lg[base]), 32'h11);
    chk("R8 order 2", 32'(lg[base+1]), 32'h01);

    // R3 buffer holding only urgent commands does not preempt
    abort_en = 1'b1;
    setc(0, 8'h02); q_valid = 4'b0001;
    cyc(); setc(0, 8'h03);
    #1 chk("R3 urgent-only buffer no preempt", 32'(q_ready), 32'b0001);
    cyc(); q_valid = '0;
    #1 chk("R3 no abort", 32'(abort_req), 32'd0);
    buf_ready = 1'b1;
    cyc(); cyc();
    buf_ready = 1'b0;

    // R3..R7 full preemption with two saved commands
    setc(1, 8'h11); q_valid = 4'b0010;
    cyc(); setc(2, 8'h21); q_valid = 4'b0100;
    cyc(); setc(0, 8'h0A); q_valid = 4'b0001;
    #1 chk("R3 preempt cycle no accept", 32'(q_ready), 32'd0);
    cyc();
    chk("R3 output withdrawn", 32'(buf_valid), 32'd0);
    cyc();
    q_valid = 4'b1111; setc(1, 8'h12); setc(2, 8'h22); setc(3, 8'h32);
    #1 chk("R4 abort raised", 32'(abort_req), 32'd1);
    chk("R7 all blocked in abort", 32'(q_ready), 32'd0);
    chk("R4 output quiet", 32'(buf_valid), 32'd0);
    cyc(); cyc();
    chk("R4 abort held", 32'(abort_req), 32'd1);
    abort_done = 1'b1;
    cyc(); abort_done = 1'b0;
    #1 chk("R5 abort released", 32'(abort_req), 32'd0);
    chk("R5 only urgent ready", 32'(q_ready), 32'b0001);
    buf_ready = 1'b1; base = nl;
    cyc(); setc(0, 8'h0B);
    cyc(); q_valid = 4'b1110;
    #1 chk("R7 low blocked after drain", 32'(q_ready), 32'd0);
    cyc();
    chk("R6 restore blocks low", 32'(q_ready), 32'd0);
    cyc(); cyc();
    chk("R6 normal resumes", 32'(q_ready), 32'b0010);
    cyc(); q_valid = '0;
    cyc(); cyc(); cyc();
    buf_ready = 1'b0;
    chk("R6 out 1 urgent", 32'(lg[base]), 32'h0A);
    chk("R6 out 2 urgent", 32'(lg[base+1]), 32'h0B);
    chk("R6 out 3 restored", 32'(lg[base+2]), 32'h11);
    chk("R6 out 4 restored", 32'(lg[base+3]), 32'h21);
    chk("R6 out 5 later low", 32'(lg[base+4]), 32'h12);
    chk("R6 out count", 32'(nl - base), 32'd5);

    // R9 nothing left to save
    setc(3, 8'h31); q_valid = 4'b1000;
    cyc(); setc(0, 8'h05); q_valid = 4'b0001; buf_ready = 1'b1; base = nl;
    #1 chk("R3 preempt with one low", 32'(q_ready), 32'd0);
    cyc(); cyc();
    abort_done = 1'b1;
    cyc(); abort_done = 1'b0;
    cyc(); setc(1, 8'h13); q_valid = 4'b0010;
    cyc();
    chk("R9 restore skipped", 32'(q_ready), 32'b0010);
    cyc(); q_valid = '0;
    cyc(); cyc();
    buf_ready = 1'b0;
    chk("R9 out 1", 32'(lg[base]), 32'h31);
    chk("R9 out 2", 32'(lg[base+1]), 32'h05);
    chk("R9 out 3", 32'(lg[base+2]), 32'h13);
    chk("R9 out count", 32'(nl - base), 32'd3);

    summary();
  end
endmodule